// File: doc/BRIEF.md
# Circular Message Frame Queue Manager

This block keeps four circular queues of 32-bit message frame addresses inside one memory area that sits on a 1 MB boundary. The queues are carved from that area in a fixed order: inbound free, inbound post, outbound free, outbound post. Each queue is sized by a code from the control register shifted left by 11 bits, giving the region size in bytes. The block holds a head and a tail pointer per queue. It reaches the frame storage through a simple word request interface with an acknowledge.

A host sees two port registers. On the inbound port, a read hands out a free frame and a write posts a frame for the local processor. On the outbound port, a read collects a frame the local side has posted, and a write gives a frame back to the outbound free pool. Each port access is a one-cycle request pulse. The block answers it with a one-cycle acknowledge. The local side programs the control word and the base address, and can read and write every pointer directly. It uses these pointer writes to produce and consume the queue ends that the host ports do not cover.

Top module: `mfq_top`

## Requirements
- R1: A base address write whose low 20 bits are not all zero is ignored, and the base register keeps its old value. The base register is at register address 1.
- R2: An accepted base write sets the head and tail of queue k (k = 0 inbound free, 1 inbound post, 2 outbound free, 3 outbound post) to base + k*(code<<11). Register address 2+2k reads head k and 3+2k reads tail k.
- R3: The control register at register address 0 holds the enable in bit 0 and a 5-bit size code in bits 12:8. It resets to zero and reads back what was written.
- R4: A queue is empty when its head equals its tail. An inbound port read of an empty inbound free queue returns 0xFFFFFFFF and makes no memory request.
- R5: An inbound port read of a non-empty inbound free queue returns the memory word at its tail and advances the tail by 4.
- R6: An inbound port write stores the data at the inbound post head and advances the head by 4. post_pending is high whenever the inbound post head differs from its tail.
- R7: A pointer that would advance onto the end of its queue region wraps to the start of that region instead.
- R8: A port write whose advanced head would equal the tail is refused. No memory write is made, the head is unchanged, and overflow is high for one cycle together with the acknowledge.
- R9: An outbound port read pops from the outbound post queue, returning 0xFFFFFFFF when it is empty. An outbound port write pushes onto the outbound free queue.
- R10: While enable is clear, port reads return 0xFFFFFFFF, port writes are dropped, and no memory request is made.
- R11: Pointer registers are writable from the local register interface. A memory request holds its address stable until acknowledged. Each port request produces exactly one single-cycle acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Local register write strobe |
| reg_addr | input | 4 | Local register address |
| reg_wdata | input | 32 | Local register write data |
| reg_rdata | output | 32 | Local register read data (combinational) |
| port_req | input | 1 | Host port request pulse |
| port_sel | input | 1 | 0 inbound port, 1 outbound port |
| port_wr | input | 1 | 1 write, 0 read |
| port_wdata | input | 32 | Host port write data |
| port_ack | output | 1 | Host port completion pulse |
| port_rdata | output | 32 | Host port read data, valid with port_ack |
| mem_req | output | 1 | Memory word request |
| mem_wr | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| post_pending | output | 1 | Inbound post queue not empty |
| overflow | output | 1 | Refused-write pulse |

## Verification
Every cycle, the assertions watch the memory handshake and the port side. A pending memory request must keep its address. Acknowledges must be single pulses. A refused write must not touch memory. A new request must never start while the queues were disabled. Pointers must hold when nothing writes or advances them, and the base register must stay aligned. Only the bench scenarios can show the data path itself: that pops return the stored frame, that pushes land at the right address, that pointers start at the right region offsets and wrap at region ends, and that empty, full and disabled cases give all-ones or refusal.

// File: rtl/mfq_pkg.sv
package mfq_pkg;
    localparam int NQ   = 4;
    localparam int NPTR = 2 * NQ;
    localparam int PIW  = $clog2(NPTR);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } fsm_st_e;
endpackage

// File: rtl/mfq_region_map.sv
module mfq_region_map
    import mfq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CODE_W = 5,
    parameter int SHIFT  = 11
) (
    input  logic [ADDR_W-1:0]           base,
    input  logic [CODE_W-1:0]           code,
    output logic [NQ-1:0][ADDR_W-1:0]   starts,
    output logic [NQ-1:0][ADDR_W-1:0]   ends
);
    logic [ADDR_W-1:0] span;
    assign span = ADDR_W'(code) << SHIFT;

    for (genvar k = 0; k < NQ; k++) begin : g_region
        assign starts[k] = base + ADDR_W'(k) * span;
        assign ends[k]   = base + ADDR_W'(k + 1) * span;
    end
endmodule

// File: rtl/mfq_ptr_bank.sv
module mfq_ptr_bank
    import mfq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        init,
    input  logic [NQ-1:0][ADDR_W-1:0]   starts,
    input  logic                        wr_en,
    input  logic [PIW-1:0]              wr_idx,
    input  logic [ADDR_W-1:0]           wr_data,
    input  logic                        adv_en,
    input  logic [PIW-1:0]              adv_idx,
    input  logic [ADDR_W-1:0]           adv_val,
    output logic [NPTR-1:0][ADDR_W-1:0] ptrs
);
    logic [NPTR-1:0][ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (init) begin
            for (int k = 0; k < NQ; k++) begin
                ptr_d[2*k]   = starts[k];
                ptr_d[2*k+1] = starts[k];
            end
        end else if (wr_en) begin
            ptr_d[wr_idx] = wr_data;
        end else if (adv_en) begin
            ptr_d[adv_idx] = adv_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptrs = ptr_q;

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !wr_en && !adv_en) |=> $stable(ptr_q)); // R11
endmodule

// File: rtl/mfq_port_fsm.sv
module mfq_port_fsm
    import mfq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic [NPTR-1:0][ADDR_W-1:0] ptrs,
    input  logic [NQ-1:0][ADDR_W-1:0]   starts,
    input  logic [NQ-1:0][ADDR_W-1:0]   ends,
    input  logic                        port_req,
    input  logic                        port_sel,
    input  logic                        port_wr,
    input  logic [DATA_W-1:0]           port_wdata,
    output logic                        port_ack,
    output logic [DATA_W-1:0]           port_rdata,
    output logic                        overflow,
    output logic                        mem_req,
    output logic                        mem_wr,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic                        mem_ack,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic                        adv_en,
    output logic [PIW-1:0]              adv_idx,
    output logic [ADDR_W-1:0]           adv_val
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        fsm_st_e           st;
        logic              ack;
        logic              ovf;
        logic [DATA_W-1:0] rdata;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [PIW-1:0]    idx;
        logic [ADDR_W-1:0] nxt;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [1:0]        qi;
    logic [ADDR_W-1:0] head, tail, cur, inc, step;

    always_comb begin
        // queue picked by port and direction: in-rd 0, in-wr 1, out-wr 2, out-rd 3
        qi   = {port_sel, port_sel ^ port_wr};
        head = ptrs[{qi, 1'b0}];
        tail = ptrs[{qi, 1'b1}];
        cur  = port_wr ? head : tail;
        inc  = cur + ADDR_W'(4);
        step = (inc == ends[qi]) ? starts[qi] : inc;

        s_d     = s_q;
        s_d.ack = 1'b0;
        s_d.ovf = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (port_req) begin
                    if (!enable || (!port_wr && head == tail)) begin
                        s_d.ack   = 1'b1;
                        s_d.rdata = ALL_ONES;
                    end else if (port_wr && step == tail) begin
                        s_d.ack   = 1'b1;
                        s_d.ovf   = 1'b1;
                        s_d.rdata = ALL_ONES;
                    end else begin
                        s_d.st    = ST_MEM;
                        s_d.addr  = cur;
                        s_d.wr    = port_wr;
                        s_d.wdata = port_wdata;
                        s_d.idx   = {qi, ~port_wr};
                        s_d.nxt   = step;
                    end
                end
            end
            ST_MEM: begin
                if (mem_ack) begin
                    s_d.st    = ST_IDLE;
                    s_d.ack   = 1'b1;
                    s_d.rdata = s_q.wr ? ALL_ONES : mem_rdata;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign port_ack   = s_q.ack;
    assign port_rdata = s_q.rdata;
    assign overflow   = s_q.ovf;
    assign mem_req    = (s_q.st == ST_MEM);
    assign mem_wr     = s_q.wr;
    assign mem_addr   = s_q.addr;
    assign mem_wdata  = s_q.wdata;
    assign adv_en     = (s_q.st == ST_MEM) && mem_ack;
    assign adv_idx    = s_q.idx;
    assign adv_val    = s_q.nxt;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R11
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        port_ack |=> !port_ack); // R11
    AST_NO_MEM_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(enable)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (port_ack && !mem_req)); // R8
endmodule

// File: rtl/mfq_top.sv
module mfq_top
    import mfq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CODE_W     = 5,
    parameter int CODE_LSB   = 8,
    parameter int SIZE_SHIFT = 11,
    parameter int ALIGN_BITS = 20,
    parameter int REG_AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              port_req,
    input  logic              port_sel,
    input  logic              port_wr,
    input  logic [DATA_W-1:0] port_wdata,
    output logic              port_ack,
    output logic [DATA_W-1:0] port_rdata,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              post_pending,
    output logic              overflow
);
    localparam logic [REG_AW-1:0] RA_CTRL = REG_AW'(0);
    localparam logic [REG_AW-1:0] RA_BASE = REG_AW'(1);
    localparam logic [REG_AW-1:0] RA_PTR0 = REG_AW'(2);

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic [ADDR_W-1:0] base;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic init;
    logic ptr_wr;
    logic [PIW-1:0] ptr_widx;

    logic [NQ-1:0][ADDR_W-1:0]   starts, ends;
    logic [NPTR-1:0][ADDR_W-1:0] ptrs;
    logic              adv_en;
    logic [PIW-1:0]    adv_idx;
    logic [ADDR_W-1:0] adv_val;

    always_comb begin
        cfg_d    = cfg_q;
        init     = 1'b0;
        ptr_wr   = 1'b0;
        ptr_widx = PIW'(reg_addr - RA_PTR0);
        if (reg_wr) begin
            if (reg_addr == RA_CTRL) begin
                cfg_d.en   = reg_wdata[0];
                cfg_d.code = reg_wdata[CODE_LSB +: CODE_W];
            end else if (reg_addr == RA_BASE) begin
                if (reg_wdata[ALIGN_BITS-1:0] == '0) begin
                    cfg_d.base = ADDR_W'(reg_wdata);
                    init       = 1'b1;
                end
            end else if (reg_addr >= RA_PTR0 && reg_addr < RA_PTR0 + REG_AW'(NPTR)) begin
                ptr_wr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == RA_CTRL) begin
            reg_rdata[0] = cfg_q.en;
            reg_rdata[CODE_LSB +: CODE_W] = cfg_q.code;
        end else if (reg_addr == RA_BASE) begin
            reg_rdata = 32'(cfg_q.base);
        end else if (reg_addr >= RA_PTR0 && reg_addr < RA_PTR0 + REG_AW'(NPTR)) begin
            reg_rdata = 32'(ptrs[ptr_widx]);
        end
    end

    // region starts follow the next config so init lands on the new base
    mfq_region_map #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .SHIFT(SIZE_SHIFT)) u_map (
        .base   (cfg_d.base),
        .code   (cfg_d.code),
        .starts (starts),
        .ends   (ends)
    );

    mfq_ptr_bank #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (init),
        .starts  (starts),
        .wr_en   (ptr_wr),
        .wr_idx  (ptr_widx),
        .wr_data (ADDR_W'(reg_wdata)),
        .adv_en  (adv_en),
        .adv_idx (adv_idx),
        .adv_val (adv_val),
        .ptrs    (ptrs)
    );

    mfq_port_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_q.en),
        .ptrs       (ptrs),
        .starts     (starts),
        .ends       (ends),
        .port_req   (port_req),
        .port_sel   (port_sel),
        .port_wr    (port_wr),
        .port_wdata (port_wdata),
        .port_ack   (port_ack),
        .port_rdata (port_rdata),
        .overflow   (overflow),
        .mem_req    (mem_req),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .adv_en     (adv_en),
        .adv_idx    (adv_idx),
        .adv_val    (adv_val)
    );

    assign post_pending = (ptrs[2] != ptrs[3]);

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.base[ALIGN_BITS-1:0] == '0); // R1
endmodule

// File: tb/sim_mfq_top.sv
`timescale 1ns/1ps
module sim_mfq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        port_req = 1'b0, port_sel = 1'b0, port_wr = 1'b0;
    logic [31:0] port_wdata = '0;
    logic        port_ack;
    logic [31:0] port_rdata;
    logic        mem_req, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        post_pending, overflow;

    always #2 clk = ~clk;

    mfq_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_req(port_req),
        .port_sel(port_sel), .port_wr(port_wr), .port_wdata(port_wdata),
        .port_ack(port_ack), .port_rdata(port_rdata), .mem_req(mem_req),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .post_pending(post_pending),
        .overflow(overflow)
    );

    localparam logic [31:0] BASE = 32'h0010_0000;
    localparam logic [31:0] IF_S = BASE;
    localparam logic [31:0] IP_S = BASE + 32'h800;
    localparam logic [31:0] OF_S = BASE + 32'h1000;
    localparam logic [31:0] OP_S = BASE + 32'h1800;

    // memory model, two-cycle acknowledge
    logic [31:0] mem [2048];
    int mem_cnt = 0;
    int lat = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat <= 0;
        end else if (mem_req && !mem_ack) begin
            if (lat == 1) begin
                mem_ack <= 1'b1;
                lat <= 0;
                mem_cnt <= mem_cnt + 1;
                if (mem_wr) mem[mem_addr[12:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[12:2]];
            end else begin
                lat <= lat + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    logic cur_rd = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (port_ack && cur_rd) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 unexpected ack actual=%h expected=none", port_rdata);
            end else begin
                chk(tag_q.pop_front(), port_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic port_op(input logic sel, input logic wr, input logic [31:0] wd,
                           input logic [31:0] exp, input logic exp_ovf, input string tag);
        int n;
        @(negedge clk);
        cur_rd = !wr;
        if (!wr) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        port_req = 1'b1; port_sel = sel; port_wr = wr; port_wdata = wd;
        @(negedge clk);
        port_req = 1'b0;
        n = 0;
        while (!port_ack && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (!port_ack) begin
            checks++; errors++;
            $display("FAIL R11 %s no ack actual=0 expected=1", tag);
        end
        chk({tag, " overflow"}, {31'd0, overflow}, {31'd0, exp_ovf});
        @(negedge clk);
        chk({tag, " single ack"}, {31'd0, port_ack}, 32'd0);
    endtask

    initial begin
        int c0;
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        reg_check(4'd0, 32'h0, "R3 ctrl reset");
        chk("R11 reset ack/mem/flags", {29'd0, port_ack, mem_req, post_pending | overflow}, 32'd0);

        // R3 control, R1 alignment, R2 init
        reg_write(4'd0, 32'h0000_0100);
        reg_check(4'd0, 32'h0000_0100, "R3 ctrl readback");
        reg_write(4'd1, 32'h0012_3000);
        reg_check(4'd1, 32'h0, "R1 misaligned base ignored");
        reg_write(4'd1, BASE);
        reg_check(4'd1, BASE, "R1 aligned base accepted");
        reg_check(4'd2, IF_S, "R2 IF head"); reg_check(4'd3, IF_S, "R2 IF tail");
        reg_check(4'd4, IP_S, "R2 IP head"); reg_check(4'd5, IP_S, "R2 IP tail");
        reg_check(4'd6, OF_S, "R2 OF head"); reg_check(4'd7, OF_S, "R2 OF tail");
        reg_check(4'd8, OP_S, "R2 OP head"); reg_check(4'd9, OP_S, "R2 OP tail");

        // R10 disabled
        c0 = mem_cnt;
        reg_write(4'd2, IF_S + 32'd8);
        port_op(1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF, 1'b0, "R10 disabled read");
        port_op(1'b0, 1'b1, 32'h55, 32'h0, 1'b0, "R10 disabled write");
        reg_check(4'd4, IP_S, "R10 IP head unchanged");
        reg_check(4'd3, IF_S, "R10 IF tail unchanged");
        chk("R10 no memory requests", 32'(mem_cnt - c0), 32'd0);
        reg_write(4'd2, IF_S);

        reg_write(4'd0, 32'h0000_0101);
        reg_check(4'd0, 32'h0000_0101, "R3 enable readback");

        // R4 empty
        c0 = mem_cnt;
        port_op(1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF, 1'b0, "R4 empty inbound read");
        chk("R4 no memory request", 32'(mem_cnt - c0), 32'd0);

        // R5 pops, R11 local pointer write
        mem[IF_S[12:2]]      = 32'hF00D_0000;
        mem[IF_S[12:2] + 1]  = 32'hF00D_0004;
        reg_write(4'd2, IF_S + 32'd8);
        reg_check(4'd2, IF_S + 32'd8, "R11 pointer writable");
        port_op(1'b0, 1'b0, 32'h0, 32'hF00D_0000, 1'b0, "R5 first pop");
        port_op(1'b0, 1'b0, 32'h0, 32'hF00D_0004, 1'b0, "R5 second pop");
        reg_check(4'd3, IF_S + 32'd8, "R5 IF tail advanced");
        port_op(1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF, 1'b0, "R4 drained read");

        // R6 post
        port_op(1'b0, 1'b1, 32'h0000_A5A5, 32'h0, 1'b0, "R6 inbound post");
        chk("R6 stored at IP head", mem[IP_S[12:2]], 32'h0000_A5A5);
        reg_check(4'd4, IP_S + 32'd4, "R6 IP head advanced");
        chk("R6 post_pending high", {31'd0, post_pending}, 32'd1);

        // R7 wrap
        reg_write(4'd4, IP_S + 32'h7FC);
        reg_write(4'd5, IP_S + 32'd8);
        port_op(1'b0, 1'b1, 32'h0000_BEEF, 32'h0, 1'b0, "R7 post at region end");
        chk("R7 stored at last slot", mem[(IP_S[12:2]) + 11'd511], 32'h0000_BEEF);
        reg_check(4'd4, IP_S, "R7 head wrapped to region start");

        // R8 overflow
        reg_write(4'd5, IP_S + 32'd4);
        c0 = mem_cnt;
        port_op(1'b0, 1'b1, 32'h0000_DEAD, 32'h0, 1'b1, "R8 full post refused");
        reg_check(4'd4, IP_S, "R8 head unchanged");
        chk("R8 no memory write", 32'(mem_cnt - c0), 32'd0);
        reg_write(4'd5, IP_S);
        chk("R6 post_pending low when empty", {31'd0, post_pending}, 32'd0);

        // R9 outbound
        port_op(1'b1, 1'b0, 32'h0, 32'hFFFF_FFFF, 1'b0, "R9 empty outbound read");
        port_op(1'b1, 1'b1, 32'h0000_0F0F, 32'h0, 1'b0, "R9 outbound free push");
        chk("R9 stored at OF head", mem[OF_S[12:2]], 32'h0000_0F0F);
        reg_check(4'd6, OF_S + 32'd4, "R9 OF head advanced");
        mem[OP_S[12:2]] = 32'h0000_1234;
        reg_write(4'd8, OP_S + 32'd4);
        port_op(1'b1, 1'b0, 32'h0, 32'h0000_1234, 1'b0, "R9 outbound pop");
        reg_check(4'd9, OP_S + 32'd4, "R9 OP tail advanced");

        chk("R11 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finish_up();
    end

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end
endmodule